// File: doc/BRIEF.md
# Address-Triggered Event Latch with Miss Detection

This block holds the pending-event state for eight quick-DMA channels. Each channel has a mapping register that names one parameter-memory entry and one 32-bit trigger word inside that entry. The block watches two write streams. One is ordinary writes on the parameter-memory bus from any master. The other is link-update writes issued by the channel controller. When a write lands on a channel's mapped trigger word and that channel is enabled, the channel's event bit is set.

An event bit stays set until the downstream scheduler acknowledges that the channel's transfer request has been submitted. A trigger that arrives while the bit is still set is recorded in a separate missed-event register, which software clears by writing ones to it. The event vector is also driven straight out as `evt_pending` for an external prioritizer.

Both write streams are plain valid-qualified observations. The block never stalls a write, so there is no ready signal and no back-pressure. The register port performs a write in any cycle where `cfg_we` is high, and read data is a combinational function of `cfg_raddr`.

Top module: `qtrig_event_latch`

## Requirements
- R1: After reset, the event, missed-event and enable registers read 0, every mapping register reads 0, and `evt_pending` is 0.
- R2: A parameter-bus write (`pbus_valid`=1) whose word address `pbus_addr[13:2]` equals {entry, word} of an enabled channel sets that channel's event bit at the next clock edge. `evt_pending` always equals the event register.
- R3: A link-update write (`link_valid`=1) that matches a channel's mapping in the same way also sets that channel's event bit at the next edge.
- R4: A trigger on a channel whose enable bit (register index 2, bit n = channel n) is 0 changes neither its event bit nor its missed bit. The enable register is read/write.
- R5: Address bits 1:0 are ignored. A write to a different word of the mapped entry, or to another entry, sets nothing.
- R6: A one-hot bit in `submit_ack` clears that channel's event bit at the next edge. If a trigger for the same channel occurs in the same cycle, the event bit stays 1.
- R7: A trigger on a channel whose event bit is already 1 sets that channel's missed bit (register index 1). The event bit stays 1. This holds even when an acknowledge arrives in the same cycle.
- R8: Writing to register index 1 clears each missed bit written as 1 and leaves the bits written as 0 unchanged. A new miss in the same cycle as the clear of that bit leaves the bit at 1.
- R9: The event register (index 0) is read-only, so writes to it have no effect. Bits 31:8 of the event, missed and enable registers read 0.
- R10: Any number of channels may be set in one cycle, including one hit from each source and several channels mapped to the same word.
- R11: Mapping register for channel n sits at index 4+n. The entry index is held in bits 8:0 and the word index in bits 18:16, and both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pbus_valid | input | 1 | A parameter-memory bus write is present this cycle |
| pbus_addr | input | 14 | Byte address of that bus write |
| link_valid | input | 1 | A controller link-update write is present this cycle |
| link_addr | input | 14 | Byte address of that link-update write |
| submit_ack | input | 8 | One-hot: this channel's request was submitted |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 4 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 4 | Register read index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| evt_pending | output | 8 | Current event vector |

## Verification
Every state change is registered once, so a trigger, acknowledge or register write applied in cycle N shows in `evt_pending` and `cfg_rdata` after the rising edge that ends cycle N. Readback adds no further delay. The driver holds each stimulus for exactly one cycle from a falling edge and returns the inputs to idle at the next falling edge. Only then does it queue the expected values. The monitor compares them at that falling edge, one full edge after the update, while all inputs are idle. The driver waits for the queue to drain before the next stimulus, so no comparison can overlap a later change.

// File: rtl/qtrig_pkg.sv
package qtrig_pkg;
  localparam int REG_EVT  = 0;
  localparam int REG_MISS = 1;
  localparam int REG_EN   = 2;
  localparam int REG_MAP0 = 4;
  localparam int MAP_WORD_LSB = 16;
endpackage

// File: rtl/qtrig_map_bank.sv
module qtrig_map_bank #(
  parameter int NCH     = 8,
  parameter int ENTRY_W = 9,
  parameter int WORD_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CFG_AW  = 4,
  localparam int MAP_W  = ENTRY_W + WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_waddr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [NCH*MAP_W-1:0] map_flat
);
  import qtrig_pkg::*;

  for (genvar n = 0; n < NCH; n++) begin : g_map
    logic [ENTRY_W-1:0] entry_q;
    logic [WORD_W-1:0]  word_q;
    logic               sel;
    assign sel = cfg_we && (int'(cfg_waddr) == REG_MAP0 + n);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q <= '0;
        word_q  <= '0;
      end else if (sel) begin
        entry_q <= cfg_wdata[ENTRY_W-1:0];
        word_q  <= cfg_wdata[MAP_WORD_LSB +: WORD_W];
      end
    end
    // word-address form: entry*32 + word*4, shifted right by 2
    assign map_flat[n*MAP_W +: MAP_W] = {entry_q, word_q};
  end
endmodule

// File: rtl/qtrig_addr_match.sv
module qtrig_addr_match #(
  parameter int NCH     = 8,
  parameter int ENTRY_W = 9,
  parameter int WORD_W  = 3,
  localparam int MAP_W  = ENTRY_W + WORD_W,
  localparam int ADDR_W = MAP_W + 2
) (
  input  logic [NCH*MAP_W-1:0] map_flat,
  input  logic [NCH-1:0]       enable,
  input  logic                 pbus_valid,
  input  logic [ADDR_W-1:0]    pbus_addr,
  input  logic                 link_valid,
  input  logic [ADDR_W-1:0]    link_addr,
  output logic [NCH-1:0]       trig
);
  for (genvar n = 0; n < NCH; n++) begin : g_cmp
    logic [MAP_W-1:0] loc;
    logic hit_bus, hit_link;
    assign loc      = map_flat[n*MAP_W +: MAP_W];
    assign hit_bus  = pbus_valid && (pbus_addr[ADDR_W-1:2] == loc);
    assign hit_link = link_valid && (link_addr[ADDR_W-1:2] == loc);
    assign trig[n]  = enable[n] && (hit_bus || hit_link);
  end
endmodule

// File: rtl/qtrig_evt_state.sv
module qtrig_evt_state #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] trig,
  input  logic [NCH-1:0] ack,
  input  logic [NCH-1:0] miss_clr,
  output logic [NCH-1:0] evt_q,
  output logic [NCH-1:0] miss_q
);
  for (genvar n = 0; n < NCH; n++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_q[n]  <= 1'b0;
        miss_q[n] <= 1'b0;
      end else begin
        // set dominates the hardware clear
        evt_q[n]  <= trig[n] | (evt_q[n] & ~ack[n]);
        // a fresh miss dominates the software clear
        miss_q[n] <= (trig[n] & evt_q[n]) | (miss_q[n] & ~miss_clr[n]);
      end
    end
  end
endmodule

// File: rtl/qtrig_event_latch.sv
module qtrig_event_latch #(
  parameter int NCH     = 8,
  parameter int ENTRY_W = 9,
  parameter int WORD_W  = 3,
  parameter int DATA_W  = 32,
  parameter int CFG_AW  = 4,
  localparam int MAP_W  = ENTRY_W + WORD_W,
  localparam int ADDR_W = MAP_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pbus_valid,
  input  logic [ADDR_W-1:0] pbus_addr,
  input  logic              link_valid,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic [NCH-1:0]    submit_ack,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [NCH-1:0]    evt_pending
);
  import qtrig_pkg::*;

  logic [NCH*MAP_W-1:0] map_flat;
  logic [NCH-1:0]       enable_q, trig_vec, evt_q, miss_q, miss_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       enable_q <= '0;
    else if (cfg_we && int'(cfg_waddr) == REG_EN)     enable_q <= cfg_wdata[NCH-1:0];
  end

  assign miss_clr = (cfg_we && int'(cfg_waddr) == REG_MISS) ? cfg_wdata[NCH-1:0] : '0;

  qtrig_map_bank #(.NCH(NCH), .ENTRY_W(ENTRY_W), .WORD_W(WORD_W),
                   .DATA_W(DATA_W), .CFG_AW(CFG_AW)) u_map (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .map_flat(map_flat));

  qtrig_addr_match #(.NCH(NCH), .ENTRY_W(ENTRY_W), .WORD_W(WORD_W)) u_match (
    .map_flat(map_flat), .enable(enable_q),
    .pbus_valid(pbus_valid), .pbus_addr(pbus_addr),
    .link_valid(link_valid), .link_addr(link_addr), .trig(trig_vec));

  qtrig_evt_state #(.NCH(NCH)) u_state (
    .clk(clk), .rst_n(rst_n), .trig(trig_vec), .ack(submit_ack),
    .miss_clr(miss_clr), .evt_q(evt_q), .miss_q(miss_q));

  assign evt_pending = evt_q;

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_raddr) == REG_EVT)       cfg_rdata[NCH-1:0] = evt_q;
    else if (int'(cfg_raddr) == REG_MISS) cfg_rdata[NCH-1:0] = miss_q;
    else if (int'(cfg_raddr) == REG_EN)   cfg_rdata[NCH-1:0] = enable_q;
    else begin
      for (int n = 0; n < NCH; n++) begin
        if (int'(cfg_raddr) == REG_MAP0 + n) begin
          cfg_rdata[ENTRY_W-1:0] = map_flat[n*MAP_W+WORD_W +: ENTRY_W];
          cfg_rdata[MAP_WORD_LSB +: WORD_W] = map_flat[n*MAP_W +: WORD_W];
        end
      end
    end
  end
endmodule

// File: rtl/qtrig_event_latch_chk.sv
module qtrig_event_latch_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] trig,
  input logic [NCH-1:0] pending,
  input logic [NCH-1:0] miss,
  input logic [NCH-1:0] ack,
  input logic [NCH-1:0] enable
);
  AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((pending & $past(trig)) == $past(trig))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pending & ~$past(pending) & ~$past(trig)) == '0)); // R9
  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pending & ~$past(pending) & ~$past(enable)) == '0)); // R4
  AST_DUP_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & pending) != '0) |=> ((miss & $past(trig & pending)) == $past(trig & pending))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~trig & pending) != '0) |=> ((pending & $past(ack & ~trig)) == '0)); // R6
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack)); // R6
endmodule

bind qtrig_event_latch qtrig_event_latch_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig_vec), .pending(evt_pending),
  .miss(miss_q), .ack(submit_ack), .enable(enable_q));

// File: tb/qtrig_event_latch_bench.sv
module qtrig_event_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PEND = -1;

  logic        clk = 0, rst_n = 0;
  logic        pbus_valid = 0, link_valid = 0, cfg_we = 0;
  logic [13:0] pbus_addr = '0, link_addr = '0;
  logic [7:0]  submit_ack = '0;
  logic [3:0]  cfg_waddr = '0, cfg_raddr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [7:0]  evt_pending;

  int errors = 0, checks = 0, outstanding = 0;
  bit done = 0;
  int          q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qtrig_event_latch u_qtrig_event_latch (
    .clk(clk), .rst_n(rst_n), .pbus_valid(pbus_valid), .pbus_addr(pbus_addr),
    .link_valid(link_valid), .link_addr(link_addr), .submit_ack(submit_ack),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .evt_pending(evt_pending));

  function automatic int ent(int n); return 10 + 3*n; endfunction
  function automatic int wrd(int n); return (n + 5) % 8; endfunction
  function automatic logic [13:0] trig_addr(int n);
    return 14'(ent(n)*32 + wrd(n)*4);
  endfunction

  task automatic expect_val(int addr, logic [31:0] v, string tag);
    q_addr.push_back(addr); q_exp.push_back(v); q_tag.push_back(tag);
    outstanding++;
  endtask

  task automatic drain();
    wait (outstanding == 0);
  endtask

  // one stimulus cycle: drive after a falling edge, idle at the next one
  task automatic step(logic pv, logic [13:0] pa, logic lv, logic [13:0] la,
                      logic [7:0] ack, logic we, logic [3:0] wa, logic [31:0] wd);
    @(negedge clk);
    pbus_valid = pv; pbus_addr = pa; link_valid = lv; link_addr = la;
    submit_ack = ack; cfg_we = we; cfg_waddr = wa; cfg_wdata = wd;
    @(negedge clk);
    pbus_valid = 0; link_valid = 0; submit_ack = '0; cfg_we = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(0, '0, 0, '0, '0, 1, a, d);
  endtask
  task automatic bus(int n, logic [1:0] off);
    step(1, trig_addr(n) | 14'(off), 0, '0, '0, 0, '0, '0);
  endtask
  task automatic lnk(int n);
    step(0, '0, 1, trig_addr(n), '0, 0, '0, '0);
  endtask
  task automatic ack(int n);
    step(0, '0, 0, '0, 8'(1 << n), 0, '0, '0);
  endtask

  // monitor: pop expected items and compare against the ports
  initial begin
    forever begin
      int a; logic [31:0] e, got; string t;
      wait (q_addr.size() != 0);
      a = q_addr.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      if (a != PEND) cfg_raddr = 4'(a);
      #1;
      got = (a == PEND) ? {24'h0, evt_pending} : cfg_rdata;
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: addr %0d actual %h expected %h", t, a, got, e);
      end
      outstanding--;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_val(0, 0, "R1 event"); expect_val(1, 0, "R1 miss");
    expect_val(2, 0, "R1 enable"); expect_val(4, 0, "R1 map0");
    expect_val(11, 0, "R1 map7"); expect_val(PEND, 0, "R1 pending");
    drain();
    // R11 program mappings
    for (int n = 0; n < 8; n++) wr(4'(4+n), 32'(ent(n)) | (32'(wrd(n)) << 16));
    expect_val(7, 32'(ent(3)) | (32'(wrd(3)) << 16), "R11 map3");
    expect_val(11, 32'(ent(7)) | (32'(wrd(7)) << 16), "R11 map7");
    drain();
    // R4 disabled channel ignores trigger
    bus(2, 0);
    expect_val(0, 0, "R4 disabled event"); expect_val(1, 0, "R4 disabled miss");
    drain();
    wr(2, 32'hFFFF_FFFF);
    expect_val(2, 32'h0000_00FF, "R4 enable rw");
    drain();
    // R9 write to event register ignored
    wr(0, 32'hFF);
    expect_val(0, 0, "R9 event readonly");
    drain();
    // R2 R5 bus hit with byte offset
    bus(2, 2'd3);
    expect_val(0, 32'h04, "R2 bus set"); expect_val(PEND, 32'h04, "R2 pending");
    drain();
    // R5 other word of a mapped entry
    step(1, 14'(ent(5)*32 + ((wrd(5)+1)%8)*4), 0, '0, '0, 0, '0, '0);
    expect_val(0, 32'h04, "R5 wrong word");
    drain();
    // R3 link hit
    lnk(5);
    expect_val(0, 32'h24, "R3 link set");
    drain();
    // R7 duplicate trigger
    bus(2, 0);
    expect_val(1, 32'h04, "R7 miss"); expect_val(0, 32'h24, "R7 event stays");
    drain();
    // R8 W1C: zeros no effect, ones clear
    wr(1, 32'h0);
    expect_val(1, 32'h04, "R8 zero write");
    drain();
    wr(1, 32'h04);
    expect_val(1, 32'h0, "R8 w1c");
    drain();
    // R6 ack clears
    ack(5);
    expect_val(0, 32'h04, "R6 ack clear");
    drain();
    // R6 R7 ack plus concurrent trigger
    step(1, trig_addr(2), 0, '0, 8'h04, 0, '0, '0);
    expect_val(0, 32'h04, "R6 set beats ack"); expect_val(1, 32'h04, "R7 miss with ack");
    drain();
    // R8 concurrent miss beats clear
    step(1, trig_addr(2), 0, '0, '0, 1, 4'd1, 32'h04);
    expect_val(1, 32'h04, "R8 miss beats clear");
    drain();
    wr(1, 32'hFF);
    expect_val(1, 0, "R8 clear all");
    drain();
    // R10 two sources, two channels, one cycle
    step(1, trig_addr(0), 1, trig_addr(7), '0, 0, '0, '0);
    expect_val(0, 32'h85, "R10 multi set"); expect_val(PEND, 32'h85, "R10 pending");
    drain();
    // R10 two channels mapped to one word
    wr(4'(4+3), 32'(ent(6)) | (32'(wrd(6)) << 16));
    bus(6, 0);
    expect_val(0, 32'hCD, "R10 shared word");
    drain();
    ack(0); ack(2); ack(3); ack(6); ack(7);
    expect_val(0, 0, "R6 all acked");
    drain();
    // R4 disable ch0 then trigger
    wr(2, 32'hFE);
    bus(0, 0);
    expect_val(0, 0, "R4 disabled again"); expect_val(1, 0, "R4 no miss");
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule